// File: doc/BRIEF.md
# Latched Status and Interrupt Controller

This block gathers alarm levels and one-cycle event pulses from the surrounding logic into a bank of latched status registers. Each status register has its own interrupt mask register. A one-hot summary register shows the host which status registers hold an unmasked pending bit. A single control bit can hold the active-low interrupt line inactive while the host services the sources.

The host polls each status register in two steps. It first writes the status register's address. Every bit written as 1 copies the current latched value into the matching position of that register's read image and clears the latch. Every bit written as 0 leaves its position untouched. A read of the same address then returns the read image. Because only the selected positions change, independent pieces of software can poll their own bits without disturbing the others.

Some condition bits are configured to request an interrupt on both the start and the end of the alarm. Other bit positions are companion event bits, which latch when a chosen condition goes away.

Top module: `status_irq_ctrl`

## Requirements

- R1: After reset, every readable address returns 0 and `irq_n` is 1.
- R2: An event position latches a one-cycle pulse on `evt_in`. A status write with a 1 in that position returns 1 in the following read and clears the latch. A second such write then returns 0.
- R3: A condition position latches while `cond_in` is 1. A clearing write made while the alarm is still present leaves the latch set. After the alarm drops, one more clearing write returns 1, and the next clearing write returns 0.
- R4: A position written as 0 in a status write keeps its previous read-image value, even when its latch is set.
- R5: If an event pulse arrives in the same cycle as a clearing write to its position, the read image receives the old latched value and the latch stays set.
- R6: Status position b of register k can pull `irq_n` low only while mask register k, bit b is 1. The interrupt follows one clock edge after the cause.
- R7: Bit k of the summary register is 1 exactly when status register k has an unmasked interrupt source. `irq_n` is low only while some summary bit is 1. Writes to the summary address have no effect.
- R8: Bit 0 of the control register is the disable bit. While it is 1, `irq_n` stays 1. Writing it back to 0 restores `irq_n` from the summary. The other control bits read as 0.
- R9: For a double-interrupt condition position, the interrupt source is a pending flag. The flag is set on each rising edge and each falling edge of the condition input, and a clearing write clears it. An alarm that stays present therefore stops requesting an interrupt once the host has cleared it.
- R10: A companion event position, at bit b+`PAIR_OFS`, latches on the falling edge of the condition input at bit b of the same register.
- R11: The address map has NUM_REGS registers in each group. Status register k is at address k. Mask register k is at address NUM_REGS+k and reads back what was written. The summary register is at 2*NUM_REGS. The control register is at 2*NUM_REGS+1.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cond_in | input | NUM_REGS*REG_W | Condition levels; bit k*REG_W+b feeds register k, bit b |
| evt_in | input | NUM_REGS*REG_W | Event pulses, same bit layout as `cond_in` |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | REG_W | Write data |
| host_rdata | output | REG_W | Read data for `host_addr` (combinational) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification

An input pulse or level is captured on the first clock edge that sees it. `irq_n` and the summary register reflect it right after that edge. A status write updates the read image on its own edge, and the read of the same address is valid in the same low clock phase. The bench drives all inputs at the falling edge and samples one falling edge later, so exactly one rising edge lies between each stimulus and its check. The double-interrupt and companion cases drop the condition and then wait one edge before checking the interrupt. The set-over-clear case puts the pulse and the clearing write on the same edge.

// File: rtl/lsic_pkg.sv
package lsic_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_INFO,
    SEL_CTRL
  } host_sel_e;

  // Address map: status group, mask group, summary, control.
  function automatic host_sel_e decode_kind(input int unsigned addr,
                                            input int unsigned nregs);
    host_sel_e kind;
    if (addr < nregs)              kind = SEL_STATUS;
    else if (addr < 2 * nregs)     kind = SEL_MASK;
    else if (addr == 2 * nregs)    kind = SEL_INFO;
    else if (addr == 2 * nregs + 1) kind = SEL_CTRL;
    else                           kind = SEL_NONE;
    return kind;
  endfunction

endpackage

// File: rtl/lsic_rst_sync.sv
module lsic_rst_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lsic_status_bank.sv
module lsic_status_bank #(
  parameter int            W        = 8,
  parameter logic [W-1:0]  COND     = 8'h0F,
  parameter logic [W-1:0]  DBL      = 8'h0C,
  parameter logic [W-1:0]  PAIR     = 8'h10,
  parameter int            PAIR_OFS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_in,
  input  logic [W-1:0] evt_in,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] latch,
  output logic [W-1:0] snap,
  output logic [W-1:0] clr_vec,
  output logic [W-1:0] irq_src
);

  logic [W-1:0] cond_q, cond_d;
  logic [W-1:0] latch_q, latch_d;
  logic [W-1:0] snap_q, snap_d;
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] rise, fall, pair_set, set_vec;

  // Companion event positions latch on the fall of their condition.
  for (genvar i = 0; i < W; i++) begin : g_pair
    if (PAIR[i] && (i >= PAIR_OFS)) begin : g_on
      assign pair_set[i] = fall[(i + W - PAIR_OFS) % W];
    end else begin : g_off
      assign pair_set[i] = 1'b0;
    end
  end

  always_comb begin
    cond_d  = cond_in & COND;
    rise    = cond_in & ~cond_q & COND;
    fall    = ~cond_in & cond_q & COND;
    set_vec = (COND & cond_in) | (~COND & (evt_in | pair_set));
    clr_vec = clr_en ? clr_bits : '0;
    // Set wins over clear in the same cycle.
    latch_d = set_vec | (latch_q & ~clr_vec);
    snap_d  = (snap_q & ~clr_vec) | (latch_q & clr_vec);
    pend_d  = DBL & (rise | fall | (pend_q & ~clr_vec));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q  <= '0;
      latch_q <= '0;
      pend_q  <= '0;
    end else begin
      cond_q  <= cond_d;
      latch_q <= latch_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (clr_en) begin
      snap_q <= snap_d;
    end
  end

  assign latch   = latch_q;
  assign snap    = snap_q;
  assign irq_src = (DBL & pend_q) | (~DBL & latch_q);

endmodule

// File: rtl/lsic_host_regs.sv
module lsic_host_regs #(
  parameter int NUM_REGS = 2,
  parameter int W        = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_sel,
  input  logic                  host_wr,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [W-1:0]          host_wdata,
  input  logic [NUM_REGS*W-1:0] snap_flat,
  input  logic [NUM_REGS-1:0]   info,
  output logic [NUM_REGS*W-1:0] mask_flat,
  output logic                  int_dis,
  output logic [NUM_REGS-1:0]   stat_wr_en,
  output logic [W-1:0]          host_rdata
);

  import lsic_pkg::*;

  host_sel_e             kind;
  logic [ADDR_W-1:0]     idx;
  logic                  wr_go;
  logic [NUM_REGS-1:0]   mask_we;
  logic                  ctrl_we;
  logic                  dis_q, dis_d;
  logic [NUM_REGS*W-1:0] mask_q;

  always_comb begin
    kind  = decode_kind(32'(host_addr), NUM_REGS);
    idx   = (kind == SEL_MASK) ? host_addr - ADDR_W'(NUM_REGS) : host_addr;
    wr_go = host_sel & host_wr;
    for (int k = 0; k < NUM_REGS; k++) begin
      stat_wr_en[k] = wr_go && (kind == SEL_STATUS) && (idx == ADDR_W'(k));
      mask_we[k]    = wr_go && (kind == SEL_MASK) && (idx == ADDR_W'(k));
    end
    ctrl_we = wr_go && (kind == SEL_CTRL);
    dis_d   = ctrl_we ? host_wdata[0] : dis_q;
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[k*W +: W] <= '0;
      end else if (mask_we[k]) begin
        mask_q[k*W +: W] <= host_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= 1'b0;
    end else begin
      dis_q <= dis_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (kind)
      SEL_STATUS: begin
        for (int k = 0; k < NUM_REGS; k++) begin
          if (idx == ADDR_W'(k)) host_rdata = snap_flat[k*W +: W];
        end
      end
      SEL_MASK: begin
        for (int k = 0; k < NUM_REGS; k++) begin
          if (idx == ADDR_W'(k)) host_rdata = mask_q[k*W +: W];
        end
      end
      SEL_INFO: host_rdata[NUM_REGS-1:0] = info;
      SEL_CTRL: host_rdata[0] = dis_q;
      default:  host_rdata = '0;
    endcase
  end

  assign mask_flat = mask_q;
  assign int_dis   = dis_q;

endmodule

// File: rtl/status_irq_ctrl.sv
module status_irq_ctrl #(
  parameter int                        NUM_REGS  = 2,
  parameter int                        REG_W     = 8,
  parameter logic [NUM_REGS*REG_W-1:0] COND_MASK = 16'h0F0F,
  parameter logic [NUM_REGS*REG_W-1:0] DBL_MASK  = 16'h0C0C,
  parameter logic [NUM_REGS*REG_W-1:0] PAIR_MASK = 16'h1010,
  parameter int                        PAIR_OFS  = 4,
  localparam int                       ADDR_W    = $clog2(2 * NUM_REGS + 2)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REGS*REG_W-1:0] cond_in,
  input  logic [NUM_REGS*REG_W-1:0] evt_in,
  input  logic                      host_sel,
  input  logic                      host_wr,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [REG_W-1:0]          host_wdata,
  output logic [REG_W-1:0]          host_rdata,
  output logic                      irq_n
);

  localparam int NBITS = NUM_REGS * REG_W;

  logic              rst_sync_n;
  logic [NBITS-1:0]  latch_flat, snap_flat, clr_flat, src_flat, mask_flat;
  logic [NUM_REGS-1:0] stat_wr_en, info;
  logic              int_dis;

  lsic_rst_sync u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_sync_n)
  );

  lsic_host_regs #(
    .NUM_REGS (NUM_REGS),
    .W        (REG_W),
    .ADDR_W   (ADDR_W)
  ) u_host (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .snap_flat  (snap_flat),
    .info       (info),
    .mask_flat  (mask_flat),
    .int_dis    (int_dis),
    .stat_wr_en (stat_wr_en),
    .host_rdata (host_rdata)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_bank
    lsic_status_bank #(
      .W        (REG_W),
      .COND     (COND_MASK[k*REG_W +: REG_W]),
      .DBL      (DBL_MASK[k*REG_W +: REG_W]),
      .PAIR     (PAIR_MASK[k*REG_W +: REG_W]),
      .PAIR_OFS (PAIR_OFS)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .cond_in  (cond_in[k*REG_W +: REG_W]),
      .evt_in   (evt_in[k*REG_W +: REG_W]),
      .clr_en   (stat_wr_en[k]),
      .clr_bits (host_wdata),
      .latch    (latch_flat[k*REG_W +: REG_W]),
      .snap     (snap_flat[k*REG_W +: REG_W]),
      .clr_vec  (clr_flat[k*REG_W +: REG_W]),
      .irq_src  (src_flat[k*REG_W +: REG_W])
    );

    assign info[k] = |(src_flat[k*REG_W +: REG_W] & mask_flat[k*REG_W +: REG_W]);
  end

  assign irq_n = ~(~int_dis & (|info));

endmodule

// File: rtl/status_irq_ctrl_chk.sv
module status_irq_ctrl_chk #(
  parameter int                        NUM_REGS  = 2,
  parameter int                        REG_W     = 8,
  parameter logic [NUM_REGS*REG_W-1:0] COND_MASK = 16'h0F0F
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_REGS*REG_W-1:0] cond_in,
  input logic [NUM_REGS*REG_W-1:0] evt_in,
  input logic [NUM_REGS*REG_W-1:0] latch_flat,
  input logic [NUM_REGS*REG_W-1:0] snap_flat,
  input logic [NUM_REGS*REG_W-1:0] clr_flat,
  input logic [NUM_REGS*REG_W-1:0] mask_flat,
  input logic [NUM_REGS-1:0]       info,
  input logic                      int_dis,
  input logic                      irq_n
);

  localparam logic [NUM_REGS*REG_W-1:0] EVT_POS = ~COND_MASK;

  // R2
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_in & EVT_POS) != '0) |=>
      ((latch_flat & $past(evt_in & EVT_POS)) == $past(evt_in & EVT_POS)));

  // R3
  cond_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cond_in & COND_MASK) != '0) |=>
      ((latch_flat & $past(cond_in & COND_MASK)) == $past(cond_in & COND_MASK)));

  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((snap_flat ^ $past(snap_flat)) & ~$past(clr_flat)) == '0));

  // R5
  set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_in & EVT_POS & clr_flat) != '0) |=>
      ((latch_flat & $past(evt_in & EVT_POS & clr_flat)) == $past(evt_in & EVT_POS & clr_flat)));

  // R6
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_flat == '0) |-> irq_n);

  // R7
  info_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (info != '0));

  // R8
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_dis |-> irq_n);

endmodule

bind status_irq_ctrl status_irq_ctrl_chk #(
  .NUM_REGS  (NUM_REGS),
  .REG_W     (REG_W),
  .COND_MASK (COND_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cond_in    (cond_in),
  .evt_in     (evt_in),
  .latch_flat (latch_flat),
  .snap_flat  (snap_flat),
  .clr_flat   (clr_flat),
  .mask_flat  (mask_flat),
  .info       (info),
  .int_dis    (int_dis),
  .irq_n      (irq_n)
);

// File: tb/test_status_irq_ctrl.sv
module test_status_irq_ctrl;

  localparam int          NR = 2;
  localparam int          W  = 8;
  localparam logic [15:0] CM = 16'h0F0F;
  localparam logic [15:0] DM = 16'h0C0C;
  localparam logic [15:0] PM = 16'h1010;
  localparam logic [2:0]  A_INFO = 3'd4;
  localparam logic [2:0]  A_CTRL = 3'd5;

  logic        clk;
  logic        rst_n;
  logic [15:0] cond_in, evt_in;
  logic        host_sel, host_wr;
  logic [2:0]  host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic        irq_n;
  logic [7:0]  d;
  int          n_chk, n_fail;
  bit          done;

  status_irq_ctrl i_status_irq_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_in    (cond_in),
    .evt_in     (evt_in),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .irq_n      (irq_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic hw(input logic [2:0] a, input logic [7:0] v);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = v;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic hr(input logic [2:0] a, output logic [7:0] v);
    host_addr = a; host_sel = 1'b1; host_wr = 1'b0;
    #1;
    v = host_rdata;
    host_sel = 1'b0;
  endtask

  task automatic poll(input int k, input logic [7:0] m, output logic [7:0] v);
    hw(3'(k), m);
    hr(3'(k), v);
  endtask

  task automatic irq_is(input string tag, input logic exp);
    check(tag, {7'd0, irq_n}, {7'd0, exp});
  endtask

  task automatic drain();
    logic [7:0] v;
    for (int k = 0; k < NR; k++) begin
      poll(k, 8'hFF, v);
      poll(k, 8'hFF, v);
      check("R2 drain", v, 8'h00);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; cond_in = '0; evt_in = '0;
    host_sel = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      hr(3'(a), d);
      check("R1 reset read", d, 8'h00);
    end
    irq_is("R1 reset irq", 1'b1);

    // R11: mask and control readback
    hw(3'd2, 8'hA5); hr(3'd2, d); check("R11 mask0", d, 8'hA5);
    hw(3'd3, 8'h5A); hr(3'd3, d); check("R11 mask1", d, 8'h5A);
    hr(3'd2, d); check("R11 mask0 kept", d, 8'hA5);
    hw(A_CTRL, 8'hFF); hr(A_CTRL, d); check("R8 ctrl bits", d, 8'h01);
    hw(A_CTRL, 8'h00); hw(3'd2, 8'h00); hw(3'd3, 8'h00);

    // Sweep every position for latching and clearing
    for (int p = 0; p < 16; p++) begin
      int k;
      int b;
      logic [7:0] bm;
      k = p / 8; b = p % 8; bm = 8'(1 << b);
      drain();
      if (!CM[p]) begin
        evt_in[p] = 1'b1; tick(); evt_in[p] = 1'b0;
        poll(k, bm, d); check("R2 event latched", d, bm);
        poll(k, bm, d); check("R2 event cleared", d, 8'h00);
      end else begin
        cond_in[p] = 1'b1; tick(); tick();
        poll(k, bm, d); check("R3 cond latched", d, bm);
        poll(k, bm, d); check("R3 cond still present", d, bm);
        cond_in[p] = 1'b0;
        poll(k, bm, d); check("R3 cond last read", d, bm);
        poll(k, bm, d); check("R3 cond cleared", d, 8'h00);
        if (b < 4) begin
          if (PM[p + 4]) begin
            poll(k, 8'(bm << 4), d); check("R10 companion latched", d, 8'(bm << 4));
            poll(k, 8'(bm << 4), d); check("R10 companion cleared", d, 8'h00);
          end
        end
      end
    end

    // R4: unselected positions hold their read image
    drain();
    evt_in[4] = 1'b1; evt_in[5] = 1'b1; tick(); evt_in[4] = 1'b0; evt_in[5] = 1'b0;
    poll(0, 8'h10, d); check("R4 only bit4 refreshed", d, 8'h10);
    poll(0, 8'h20, d); check("R4 bit4 held", d, 8'h30);
    poll(0, 8'h00, d); check("R4 zero write holds", d, 8'h30);

    // R5: set beats clear in the same cycle
    drain();
    evt_in[4] = 1'b1; tick();
    hw(3'd0, 8'h10);
    evt_in[4] = 1'b0;
    hr(3'd0, d); check("R5 old value read", d, 8'h10);
    poll(0, 8'h10, d); check("R5 latch kept", d, 8'h10);
    poll(0, 8'h10, d); check("R5 then cleared", d, 8'h00);

    // R6/R7/R9: interrupt sweep, one unmasked position at a time
    for (int p = 0; p < 16; p++) begin
      int k;
      int b;
      logic [7:0] bm;
      k = p / 8; b = p % 8; bm = 8'(1 << b);
      drain();
      if (!CM[p]) begin
        hw(3'(NR + k), ~bm);
        evt_in[p] = 1'b1; tick(); evt_in[p] = 1'b0;
        irq_is("R6 masked event", 1'b1);
        hr(A_INFO, d); check("R7 info masked", d, 8'h00);
        poll(k, bm, d);
        hw(3'(NR + k), bm);
        evt_in[p] = 1'b1; tick(); evt_in[p] = 1'b0;
        irq_is("R6 unmasked event", 1'b0);
        hr(A_INFO, d); check("R7 info names reg", d, 8'(1 << k));
        hw(A_INFO, 8'h00); hr(A_INFO, d); check("R7 info write ignored", d, 8'(1 << k));
        poll(k, bm, d);
        irq_is("R6 cleared event", 1'b1);
      end else if (!DM[p]) begin
        hw(3'(NR + k), bm);
        cond_in[p] = 1'b1; tick();
        irq_is("R6 cond irq", 1'b0);
        poll(k, bm, d);
        irq_is("R3 cond present keeps irq", 1'b0);
        cond_in[p] = 1'b0; tick();
        irq_is("R3 cond latched after drop", 1'b0);
        poll(k, bm, d);
        irq_is("R6 cond cleared", 1'b1);
      end else begin
        hw(3'(NR + k), bm);
        cond_in[p] = 1'b1; tick();
        irq_is("R9 rising edge irq", 1'b0);
        poll(k, bm, d);
        irq_is("R9 cleared while present", 1'b1);
        cond_in[p] = 1'b0; tick();
        irq_is("R9 falling edge irq", 1'b0);
        hr(A_INFO, d); check("R9 info on fall", d, 8'(1 << k));
        poll(k, bm, d);
        irq_is("R9 cleared after fall", 1'b1);
      end
      hw(3'(NR + k), 8'h00);
    end

    // R8: disable bit gates the line
    drain();
    hw(3'd3, 8'h40);
    evt_in[14] = 1'b1; tick(); evt_in[14] = 1'b0;
    irq_is("R8 enabled irq", 1'b0);
    hw(A_CTRL, 8'h01);
    irq_is("R8 disabled irq", 1'b1);
    hr(A_INFO, d); check("R8 info while disabled", d, 8'h02);
    hw(A_CTRL, 8'h00);
    irq_is("R8 re-enabled irq", 1'b0);
    poll(1, 8'h40, d); check("R8 source read", d, 8'h40);
    irq_is("R8 cleared irq", 1'b1);
    hw(3'd3, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule